// File: doc/BRIEF.md
# Cartridge Bank Address Mapper

The mapper sits between a CPU bus and the cartridge storage. Each bus access carries an 8-bit bank and a 16-bit offset. The active cartridge layout turns that address into one of three outcomes:

- a linear index into the program ROM;
- a linear index into the battery-backed RAM;
- nothing, in which case a read returns the last byte seen on the bus.

A 2-bit layout code selects one of four behaviours: no cartridge, a layout of 32 KB pages, a layout of 64 KB pages, and an extended 64 KB layout that reaches an 8 MB ROM. Two size codes give the ROM and RAM sizes. Every index is folded into the configured size, so a smaller part mirrors across its window.

Both memories are external synchronous arrays. The mapper raises a one-cycle request with the index. A read's data comes back from the memory on the next cycle, and the mapper returns it to the CPU with a valid pulse. The mapper keeps a floating-bus byte that records the most recent completed read. Reads that hit no storage return that byte.

Top module: `cart_mapper`

## Requirements
- R1: With layout code 0 (no cartridge), no ROM or RAM request is raised. Reads return the floating-bus byte, and writes have no effect.
- R2: The ROM size is 1024 << rom code and the RAM size is 1024 << ram code. Each index is the raw index modulo its size. A RAM code of 15 means no RAM is fitted, and then no RAM window answers.
- R3: Layout code 1 opens the RAM window in banks 0x70..0x7D and 0xF0..0xFF when the offset is below 0x8000. Its index is (bank[3:0] << 15) | offset.
- R4: Layout code 1 selects ROM when the RAM window misses and either the offset is 0x8000 or above or bank[6:0] is 0x40 or above. Its index is (bank[6:0] << 15) | offset[14:0].
- R5: Layout codes 2 and 3 open the RAM window when bank[6:0] is below 0x40 and the offset lies in 0x6000..0x7FFF. Its index is (bank[5:0] << 13) | offset[12:0].
- R6: Layout code 2 selects ROM when the RAM window misses and either the offset is 0x8000 or above or bank[6:0] is 0x40 or above. Its index is (bank[5:0] << 16) | offset.
- R7: Layout code 3 uses the ROM rule of R6 and adds 0x400000 to the index when bank bit 7 is 0.
- R8: A write raises a RAM write request (with the write data) only inside the RAM window. A write that hits ROM or no region raises no request at all.
- R9: A read that hits neither window returns the floating-bus byte.
- R10: The floating-bus byte is 0x00 after reset. It takes the returned data of every completed read.
- R11: A read's data appears exactly one cycle after the request, marked by a one-cycle valid pulse. A write produces no valid pulse.
- R12: Within a layout the RAM window takes priority over the ROM region, and at most one memory request is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout_i | input | 2 | Layout code (0 none, 1 32 KB pages, 2 64 KB pages, 3 extended) |
| rom_code_i | input | 4 | ROM size code |
| ram_code_i | input | 4 | RAM size code (15 = no RAM) |
| req_valid_i | input | 1 | Bus access strobe |
| req_we_i | input | 1 | 1 write, 0 read |
| bank_i | input | 8 | Address bank |
| offset_i | input | 16 | Address offset within bank |
| wdata_i | input | 8 | Write data |
| rom_re_o | output | 1 | ROM read request |
| rom_idx_o | output | 23 | Masked ROM index |
| rom_rdata_i | input | 8 | ROM data, one cycle after request |
| ram_re_o | output | 1 | RAM read request |
| ram_we_o | output | 1 | RAM write request |
| ram_idx_o | output | 19 | Masked RAM index |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM data, one cycle after request |
| rdata_o | output | 8 | Read data to the CPU |
| rvalid_o | output | 1 | Read data valid pulse |

## Verification
The hardest situation to reach is a read that falls outside every window and must return a byte left over from an earlier, unrelated read. That byte can come from a different layout or size setting than the current one. Uniform addresses almost never reach it. The random stimulus therefore draws banks and offsets from lists weighted towards window edges (0x3F/0x40, 0x6F/0x70, 0x7D/0x7E, 0xEF/0xF0, offsets 0x5FFF/0x6000, 0x7FFF/0x8000). It also changes the layout and size codes between accesses, so open-bus reads follow ROM and RAM reads made under other settings. Small RAM codes force mirrored writes onto shared cells, and reads then confirm the folded index.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

  typedef enum logic [1:0] {
    LAYOUT_NONE = 2'd0,
    LAYOUT_PAGE32 = 2'd1,
    LAYOUT_PAGE64 = 2'd2,
    LAYOUT_EXT64 = 2'd3
  } layout_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM = 2'd1,
    SRC_RAM = 2'd2,
    SRC_OPEN = 2'd3
  } src_e;

  // All-ones mask of (1 KB << code) bytes; saturates for huge codes.
  function automatic logic [31:0] size_mask(input int unsigned code);
    if (code > 21) return 32'hFFFF_FFFF;
    return (32'h0000_0400 << code) - 32'd1;
  endfunction

  // 32 KB page layout: RAM window test and indices
  function automatic logic p32_ram_window(input logic [7:0] bank, input logic [15:0] off);
    return !off[15] && ((bank >= 8'h70 && bank <= 8'h7D) || bank >= 8'hF0);
  endfunction

  function automatic logic [31:0] p32_ram_index(input logic [7:0] bank, input logic [15:0] off);
    return {13'd0, bank[3:0], off[14:0]};
  endfunction

  function automatic logic [31:0] p32_rom_index(input logic [7:0] bank, input logic [15:0] off);
    return {10'd0, bank[6:0], off[14:0]};
  endfunction

  // 64 KB page layouts: RAM window test and indices
  function automatic logic p64_ram_window(input logic [7:0] bank, input logic [15:0] off);
    return !bank[6] && (off[15:13] == 3'b011);
  endfunction

  function automatic logic [31:0] p64_ram_index(input logic [7:0] bank, input logic [15:0] off);
    return {13'd0, bank[5:0], off[12:0]};
  endfunction

  function automatic logic [31:0] p64_rom_index(input logic [7:0] bank, input logic [15:0] off,
                                                input logic upper_half);
    return {9'd0, upper_half, bank[5:0], off};
  endfunction

  // ROM region test shared by all layouts (bank bit 7 ignored)
  function automatic logic rom_region(input logic [7:0] bank, input logic [15:0] off);
    return off[15] || bank[6];
  endfunction

endpackage

// File: rtl/cart_window_decode.sv
module cart_window_decode
  import cart_mapper_pkg::*;
#(
  parameter int ROM_W = 23,
  parameter int RAM_W = 19
) (
  input  logic [1:0]       layout_i,
  input  logic [7:0]       bank_i,
  input  logic [15:0]      offset_i,
  input  logic             ram_fitted_i,
  output logic             ram_hit_o,
  output logic             rom_hit_o,
  output logic [RAM_W-1:0] ram_raw_o,
  output logic [ROM_W-1:0] rom_raw_o
);
  logic [31:0] ram_full, rom_full;
  logic        ram_win, rom_reg;

  always_comb begin
    ram_win  = 1'b0;
    rom_reg  = 1'b0;
    ram_full = '0;
    rom_full = '0;
    unique case (layout_e'(layout_i))
      LAYOUT_PAGE32: begin
        ram_win  = p32_ram_window(bank_i, offset_i);
        rom_reg  = rom_region(bank_i, offset_i);
        ram_full = p32_ram_index(bank_i, offset_i);
        rom_full = p32_rom_index(bank_i, offset_i);
      end
      LAYOUT_PAGE64, LAYOUT_EXT64: begin
        ram_win  = p64_ram_window(bank_i, offset_i);
        rom_reg  = rom_region(bank_i, offset_i);
        ram_full = p64_ram_index(bank_i, offset_i);
        rom_full = p64_rom_index(bank_i, offset_i,
                                 (layout_i == LAYOUT_EXT64) && !bank_i[7]);
      end
      default: ;
    endcase
  end

  // Priority: RAM window, then ROM region
  assign ram_hit_o = ram_win && ram_fitted_i;
  assign rom_hit_o = rom_reg && !ram_hit_o;
  assign ram_raw_o = ram_full[RAM_W-1:0];
  assign rom_raw_o = rom_full[ROM_W-1:0];
endmodule

// File: rtl/cart_size_mask.sv
module cart_size_mask
  import cart_mapper_pkg::*;
#(
  parameter int IDX_W  = 19,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [IDX_W-1:0]  raw_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [31:0] mask_full;
  assign mask_full = size_mask(int'(code_i));
  assign idx_o     = raw_i & mask_full[IDX_W-1:0];
endmodule

// File: rtl/cart_read_return.sv
module cart_read_return
  import cart_mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire_i,
  input  logic [1:0]        src_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] open_bus_o,
  output logic              miss_o
);
  logic [1:0]        src_q;
  logic              valid_q;
  logic [DATA_W-1:0] open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= SRC_NONE;
      valid_q <= 1'b0;
    end else begin
      src_q   <= rd_fire_i ? src_i : SRC_NONE;
      valid_q <= rd_fire_i;
    end
  end

  always_comb begin
    unique case (src_e'(src_q))
      SRC_ROM: rdata_o = rom_rdata_i;
      SRC_RAM: rdata_o = ram_rdata_i;
      default: rdata_o = open_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= '0;
    else if (valid_q) open_q <= rdata_o;
  end

  assign rvalid_o   = valid_q;
  assign open_bus_o = open_q;
  assign miss_o     = valid_q && (src_q == SRC_OPEN);
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_mapper_pkg::*;
#(
  parameter int ROM_W  = 23,
  parameter int RAM_W  = 19,
  parameter int CODE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        layout_i,
  input  logic [CODE_W-1:0] rom_code_i,
  input  logic [CODE_W-1:0] ram_code_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [7:0]        bank_i,
  input  logic [15:0]       offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rom_re_o,
  output logic [ROM_W-1:0]  rom_idx_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [RAM_W-1:0]  ram_idx_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [CODE_W-1:0] NO_RAM_CODE = '1;

  logic             ram_fitted, ram_hit, rom_hit, rd_fire, wr_fire;
  logic [RAM_W-1:0] ram_raw;
  logic [ROM_W-1:0] rom_raw;
  logic [1:0]       rd_src;
  logic [DATA_W-1:0] open_bus_w;
  logic             miss_w;

  assign ram_fitted = (ram_code_i != NO_RAM_CODE);
  assign rd_fire    = req_valid_i && !req_we_i;
  assign wr_fire    = req_valid_i && req_we_i;

  cart_window_decode #(.ROM_W(ROM_W), .RAM_W(RAM_W)) u_decode (
    .layout_i     (layout_i),
    .bank_i       (bank_i),
    .offset_i     (offset_i),
    .ram_fitted_i (ram_fitted),
    .ram_hit_o    (ram_hit),
    .rom_hit_o    (rom_hit),
    .ram_raw_o    (ram_raw),
    .rom_raw_o    (rom_raw)
  );

  cart_size_mask #(.IDX_W(ROM_W), .CODE_W(CODE_W)) u_rom_mask (
    .code_i (rom_code_i),
    .raw_i  (rom_raw),
    .idx_o  (rom_idx_o)
  );

  cart_size_mask #(.IDX_W(RAM_W), .CODE_W(CODE_W)) u_ram_mask (
    .code_i (ram_code_i),
    .raw_i  (ram_raw),
    .idx_o  (ram_idx_o)
  );

  assign rom_re_o    = rd_fire && rom_hit;
  assign ram_re_o    = rd_fire && ram_hit;
  assign ram_we_o    = wr_fire && ram_hit;
  assign ram_wdata_o = wdata_i;

  assign rd_src = ram_hit ? SRC_RAM : (rom_hit ? SRC_ROM : SRC_OPEN);

  cart_read_return #(.DATA_W(DATA_W)) u_return (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire_i   (rd_fire),
    .src_i       (rd_src),
    .rom_rdata_i (rom_rdata_i),
    .ram_rdata_i (ram_rdata_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .open_bus_o  (open_bus_w),
    .miss_o      (miss_w)
  );
endmodule

// File: rtl/cart_mapper_checker.sv
module cart_mapper_checker #(
  parameter int CODE_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        layout_i,
  input logic [CODE_W-1:0] ram_code_i,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic              rom_re_o,
  input logic              ram_re_o,
  input logic              ram_we_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] open_bus_w,
  input logic              miss_w
);
  assert_no_cart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (layout_i == 2'd0) |-> !(rom_re_o || ram_re_o || ram_we_o));

  assert_no_ram_fitted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_code_i == '1) |-> !(ram_re_o || ram_we_o));

  assert_write_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o |-> (req_valid_i && req_we_i)) and
    ((rom_re_o || ram_re_o) |-> (req_valid_i && !req_we_i)));

  assert_open_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_w |-> (rdata_o == open_bus_w));

  assert_open_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> (open_bus_w == $past(rdata_o)));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_we_i) |=> rvalid_o);

  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && !req_we_i) |=> !rvalid_o);

  assert_single_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_re_o, ram_re_o, ram_we_o}));
endmodule

bind cart_mapper cart_mapper_checker #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .layout_i    (layout_i),
  .ram_code_i  (ram_code_i),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .rom_re_o    (rom_re_o),
  .ram_re_o    (ram_re_o),
  .ram_we_o    (ram_we_o),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .open_bus_w  (open_bus_w),
  .miss_w      (miss_w)
);

// File: tb/cart_mapper_bench.sv
module cart_mapper_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  layout = 2'd0;
  logic [3:0]  rom_code = 4'd0;
  logic [3:0]  ram_code = 4'd0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [7:0]  bank = 8'd0;
  logic [15:0] offset = 16'd0;
  logic [7:0]  wdata = 8'd0;
  logic        rom_re, ram_re, ram_we, rvalid;
  logic [22:0] rom_idx;
  logic [18:0] ram_idx;
  logic [7:0]  ram_wdata, rdata;
  logic [7:0]  rom_q = 8'd0;
  logic [7:0]  ram_q = 8'd0;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_ram [int];
  logic [7:0] mem_ram [int];
  logic [7:0] exp_open = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_mapper u_cart_mapper (
    .clk(clk), .rst_n(rst_n), .layout_i(layout), .rom_code_i(rom_code),
    .ram_code_i(ram_code), .req_valid_i(req_valid), .req_we_i(req_we),
    .bank_i(bank), .offset_i(offset), .wdata_i(wdata),
    .rom_re_o(rom_re), .rom_idx_o(rom_idx), .rom_rdata_i(rom_q),
    .ram_re_o(ram_re), .ram_we_o(ram_we), .ram_idx_o(ram_idx),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_q),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [7:0] rom_byte(input int idx);
    return 8'((idx * 37 + (idx >> 9) * 11 + 90) % 256);
  endfunction

  // Synchronous memory models
  always @(posedge clk) begin
    if (rom_re) rom_q <= rom_byte(int'(rom_idx));
    if (ram_re) ram_q <= mem_ram.exists(int'(ram_idx)) ? mem_ram[int'(ram_idx)] : 8'h00;
    if (ram_we) mem_ram[int'(ram_idx)] = ram_wdata;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected target: 0 none, 1 rom, 2 ram, 3 open
  task automatic predict(input int lay, input int rc, input int mc, input int bk,
                         input int off, output int kind, output int idx);
    int rom_sz, ram_sz, b;
    rom_sz = 1024 << rc;
    ram_sz = (mc == 15) ? 0 : (1024 << mc);
    b = bk % 128;
    kind = 3; idx = 0;
    if (lay == 1) begin
      if (ram_sz > 0 && off < 32768 && ((bk >= 112 && bk <= 125) || bk >= 240)) begin
        kind = 2; idx = ((bk % 16) * 32768 + off) % ram_sz;
      end else if (off >= 32768 || b >= 64) begin
        kind = 1; idx = (b * 32768 + off % 32768) % rom_sz;
      end
    end else if (lay >= 2) begin
      if (ram_sz > 0 && b < 64 && off >= 24576 && off < 32768) begin
        kind = 2; idx = ((b % 64) * 8192 + off % 8192) % ram_sz;
      end else if (off >= 32768 || b >= 64) begin
        kind = 1;
        idx = ((b % 64) * 65536 + off + ((lay == 3 && bk < 128) ? 4194304 : 0)) % rom_sz;
      end
    end
  endtask

  task automatic access(input string req, input int lay, input int rc, input int mc,
                        input bit we, input int bk, input int off, input int wd);
    int kind, idx;
    logic [7:0] expd;
    @(negedge clk);
    layout = 2'(lay); rom_code = 4'(rc); ram_code = 4'(mc);
    req_valid = 1'b1; req_we = we; bank = 8'(bk); offset = 16'(off); wdata = 8'(wd);
    predict(lay, rc, mc, bk, off, kind, idx);
    #1;
    check({req, " rom_re"}, rom_re, (!we && kind == 1));
    check({req, " ram_re"}, ram_re, (!we && kind == 2));
    check({req, " ram_we (R8)"}, ram_we, (we && kind == 2));
    if (kind == 1 && !we) check({req, " rom_idx"}, rom_idx, idx);
    if (kind == 2) check({req, " ram_idx"}, ram_idx, idx);
    if (kind == 2 && we) begin
      check({req, " wdata (R8)"}, ram_wdata, wd);
      exp_ram[idx] = 8'(wd);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check({req, " rvalid (R11)"}, rvalid, !we);
    if (!we) begin
      if (kind == 1) expd = rom_byte(idx);
      else if (kind == 2) expd = exp_ram.exists(idx) ? exp_ram[idx] : 8'h00;
      else expd = exp_open;
      check({req, " rdata"}, rdata, expd);
      exp_open = expd;
    end
  endtask

  function automatic int pick_bank();
    int edges[12] = '{8'h00, 8'h3F, 8'h40, 8'h6F, 8'h70, 8'h7D, 8'h7E, 8'h7F,
                      8'h80, 8'hBF, 8'hEF, 8'hF0};
    if ($urandom_range(0, 2) == 0) return int'($urandom_range(0, 255));
    return edges[$urandom_range(0, 11)];
  endfunction

  function automatic int pick_off();
    int edges[8] = '{16'h0000, 16'h1FFF, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000,
                     16'hFFFF, 16'h6001};
    if ($urandom_range(0, 2) == 0) return int'($urandom_range(0, 65535));
    return edges[$urandom_range(0, 7)] ^ int'($urandom_range(0, 3));
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // Reset state (R10, R11)
    check("R11 reset rvalid", rvalid, 0);
    check("R10 reset rdata", rdata, 0);
    rst_n = 1'b1;
    // R1 / R10: open read in mode 0 returns 0 after reset
    access("R1 none read", 0, 10, 3, 0, 8'h00, 16'h8000, 0);
    access("R1 none write", 0, 10, 3, 1, 8'h70, 16'h0010, 8'hA5);
    access("R1 none reread", 0, 10, 3, 0, 8'h70, 16'h0010, 0);
    // R3 / R12: RAM wins over ROM region in bank 0x70
    access("R3 ram write", 1, 10, 3, 1, 8'h70, 16'h0123, 8'h3C);
    access("R3 R12 ram read", 1, 10, 3, 0, 8'h70, 16'h0123, 0);
    access("R3 R2 mirror read", 1, 10, 3, 0, 8'hF0, 16'h2123, 0);
    access("R3 bank 7D", 1, 10, 3, 0, 8'h7D, 16'h7FFF, 0);
    access("R4 bank 7E rom", 1, 10, 3, 0, 8'h7E, 16'h7FFF, 0);
    access("R4 R9 bank 3F low open", 1, 10, 3, 0, 8'h3F, 16'h7FFF, 0);
    access("R4 bank 3F high", 1, 10, 3, 0, 8'h3F, 16'h8000, 0);
    access("R4 bank 40 low", 1, 10, 3, 0, 8'h40, 16'h0000, 0);
    access("R8 rom write ignored", 1, 10, 3, 1, 8'h00, 16'h8000, 8'h77);
    access("R9 open after write", 1, 10, 3, 0, 8'h00, 16'h1000, 0);
    // R5 / R6 / R7
    access("R5 ram write", 2, 12, 4, 1, 8'h80, 16'h6000, 8'h99);
    access("R5 ram read", 2, 12, 4, 0, 8'h00, 16'h6000, 0);
    access("R9 R5 below window", 2, 12, 4, 0, 8'h00, 16'h5FFF, 0);
    access("R6 rom", 2, 13, 4, 0, 8'h41, 16'h1234, 0);
    access("R7 upper half", 3, 13, 4, 0, 8'h05, 16'h8000, 0);
    access("R7 lower half", 3, 13, 4, 0, 8'h85, 16'h8000, 0);
    access("R7 ext 8MB", 3, 13, 4, 0, 8'h7F, 16'hFFFF, 0);
    access("R2 no ram", 2, 12, 15, 0, 8'h00, 16'h6000, 0);
    access("R2 no ram write", 1, 12, 15, 1, 8'h70, 16'h0000, 8'h11);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int lay, rc, mc;
      lay = int'($urandom_range(0, 3));
      rc = int'($urandom_range(5, 13));
      mc = ($urandom_range(0, 7) == 0) ? 15 : int'($urandom_range(0, 6));
      access("R2 R12 random", lay, rc, mc, 1'($urandom_range(0, 1)),
             pick_bank(), pick_off(), int'($urandom_range(0, 255)));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule